// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer with Pulse Accumulator

The block holds one 16-bit up-counter shared by four timer channels. A seven-stage binary divider paces the counter, so the counter may advance once every 1, 2, 4, 8, 16, 32, 64 or 128 clocks. Each channel either latches the counter on a chosen edge of its pin or compares the counter against a stored value and acts on its pin when the two meet. When the counter rolls over, a sticky flag is raised, so software can count the rollovers and extend the time range.

The last channel can be taken over by a 16-bit pulse accumulator. In event mode the accumulator counts edges of that pin. In gated mode it measures how long the pin stays at its active level, in units of 64 clocks, and raises a flag when the gate closes. All flags are sticky and are cleared by writing a one to them. A per-flag enable mask combines the flags into one interrupt line.

Software reaches the block through a single-cycle register port. Writes take effect at the clock edge. Reads are combinational. The register addresses are: 0 control (bit 0 run, bits 3:1 divider select), 1 counter, 2 channel mode, 3 flags, 4 interrupt enable, 5 accumulator control (bit 0 enable, bit 1 gated, bit 2 inverted polarity), 6 accumulator count, 8 to 11 the value of channels 0 to 3. Any other address reads as zero.

Top module: `quad_timer`

## Requirements
- R1: After reset every register reads zero, all pin enables are low and the interrupt is low.
- R2: While the run bit is set, the counter advances by one on every 2^s-th clock after the write that set the bit, where s is the 3-bit divider select. The counter holds when the run bit is clear. A write to address 1 loads the counter.
- R3: When the counter wraps from 0xFFFF to 0, flag bit 4 is set.
- R4: The mode register holds a 2-bit edge field for channel i at bits 5+2i:4+2i (00 none, 01 rising, 10 falling, 11 both). A channel whose compare bit (bit i) is clear stores the counter value of the clock at which the selected pin edge is seen, and sets flag bit i.
- R5: A channel whose compare bit is set sets flag bit i on the clock at which the counter steps to its stored value. At that clock it also applies its 2-bit action at mode bits 13+2i:12+2i: 00 leaves the pin undriven, 01 toggles it, 10 drives 0, 11 drives 1. Its pin enable is high exactly when the action is not 00.
- R6: With the accumulator enabled in event mode, each active edge of pin 3 (rising when the polarity bit is 0, falling when it is 1) adds one to the accumulator and sets flag bit 6.
- R7: In gated mode the accumulator adds one every 64th clock after it is enabled, but only while pin 3 is at its active level (high when the polarity bit is 0). The end of the active level sets flag bit 6.
- R8: When the accumulator wraps from 0xFFFF to 0, flag bit 5 is set.
- R9: While the accumulator is enabled, channel 3 neither captures nor compares. Its flag bit 3 stays clear, its value is unchanged and its pin enable is low.
- R10: Writing to the flags register clears the bits written as one and leaves the others alone. A flag that is set in the same clock as a clear stays set.
- R11: The interrupt is high exactly when some flag bit is set and its enable bit at address 4 is also set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_i | input | 4 | Channel pin input levels |
| pin_o | output | 4 | Channel pin drive values |
| pin_oe | output | 4 | Channel pin drive enables |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-level rules on every clock. The counter either holds or moves by exactly one. The divider never ticks twice in a row at a slow setting. A capture loads the counter value of that clock. An idle accumulator does not move. A blocked channel keeps its value. A rollover or a channel hit always leaves its flag set. Only the bench scenarios can show the results that build up over time: the exact count reached after a given number of clocks at each divider setting, which edge codes capture, the pin level after each compare action, the accumulator totals in both modes and polarities, and the interaction of the flag clear with the interrupt mask.

// File: rtl/qt_pkg.sv
package qt_pkg;

    typedef enum logic [1:0] {
        OC_OFF    = 2'b00,
        OC_TOGGLE = 2'b01,
        OC_CLEAR  = 2'b10,
        OC_SET    = 2'b11
    } oc_act_e;

    localparam int REG_CTRL     = 0;
    localparam int REG_COUNT    = 1;
    localparam int REG_MODE     = 2;
    localparam int REG_FLAGS    = 3;
    localparam int REG_IEN      = 4;
    localparam int REG_ACC_CTRL = 5;
    localparam int REG_ACC_CNT  = 6;
    localparam int REG_CHAN     = 8;

endpackage

// File: rtl/qt_prescaler.sv
module qt_prescaler #(
    parameter int STAGES = 7,
    parameter int SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    typedef struct packed {
        logic [STAGES-1:0] div;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [STAGES-1:0] mask;

    always_comb begin
        st_d = st_q;
        mask = STAGES'((32'd1 << sel) - 32'd1);
        tick = en && ((st_q.div & mask) == mask);
        if (en) begin
            st_d.div = st_q.div + 1'b1;
        end else begin
            st_d.div = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_SLOW_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n) (tick && sel != '0) |=> (!tick || sel != $past(sel))); // R2

endmodule

// File: rtl/qt_channel.sv
module qt_channel
    import qt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blocked,
    input  logic             cmp_mode,
    input  logic [1:0]       edge_sel,
    input  logic [1:0]       act,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             cnt_step,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] val_wdata,
    input  logic             pin_i,
    output logic             pin_o,
    output logic             pin_oe,
    output logic [CNT_W-1:0] value,
    output logic             hit
);
    typedef struct packed {
        logic             pin;
        logic             out;
        logic [CNT_W-1:0] val;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic             rise, fall, cap_hit, cmp_hit;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = cnt_q + 1'b1;
        rise    = pin_i && !st_q.pin;
        fall    = !pin_i && st_q.pin;
        cap_hit = !blocked && !cmp_mode && ((edge_sel[0] && rise) || (edge_sel[1] && fall));
        cmp_hit = !blocked && cmp_mode && cnt_step && (cnt_inc == st_q.val);
        st_d.pin = pin_i;
        if (val_wr) begin
            st_d.val = val_wdata;
        end else if (cap_hit) begin
            st_d.val = cnt_q;
        end
        if (cmp_hit) begin
            case (oc_act_e'(act))
                OC_TOGGLE: st_d.out = !st_q.out;
                OC_CLEAR:  st_d.out = 1'b0;
                OC_SET:    st_d.out = 1'b1;
                default:   st_d.out = st_q.out;
            endcase
        end
    end

    assign hit    = cap_hit || cmp_hit;
    assign pin_o  = st_q.out;
    assign pin_oe = cmp_mode && !blocked && (oc_act_e'(act) != OC_OFF);
    assign value  = st_q.val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n) (cap_hit && !val_wr) |=> (st_q.val == $past(cnt_q))); // R4
    AST_OUT_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) !cmp_hit |=> $stable(st_q.out)); // R5
    AST_BLOCKED_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n) (blocked && !val_wr) |=> $stable(st_q.val)); // R9

endmodule

// File: rtl/qt_accum.sv
module qt_accum #(
    parameter int CNT_W     = 16,
    parameter int GATE_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             gated,
    input  logic             pol,
    input  logic             pin_i,
    input  logic             load,
    input  logic [CNT_W-1:0] load_data,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             evt
);
    typedef struct packed {
        logic                 pin;
        logic [GATE_LOG2-1:0] div;
        logic [CNT_W-1:0]     cnt;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic now_active, was_active, gate_tick, inc;

    always_comb begin
        st_d       = st_q;
        now_active = pin_i ^ pol;
        was_active = st_q.pin ^ pol;
        gate_tick  = en && gated && (st_q.div == '1);
        if (gated) begin
            inc = gate_tick && now_active;
            evt = en && was_active && !now_active;
        end else begin
            inc = en && now_active && !was_active;
            evt = inc;
        end
        wrap     = inc && !load && (st_q.cnt == '1);
        st_d.pin = pin_i;
        st_d.div = (en && gated) ? st_q.div + 1'b1 : '0;
        if (load) begin
            st_d.cnt = load_data;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign count = st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!inc && !load) |=> $stable(st_q.cnt)); // R6
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (inc && !load) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R7
    AST_GATE_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n) gate_tick |=> !gate_tick); // R7

endmodule

// File: rtl/quad_timer.sv
module quad_timer
    import qt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int NUM_CH     = 4,
    parameter int PRE_STAGES = 7,
    parameter int GATE_LOG2  = 6,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] pin_i,
    output logic [NUM_CH-1:0] pin_o,
    output logic [NUM_CH-1:0] pin_oe,
    output logic              irq
);
    localparam int SEL_W    = $clog2(PRE_STAGES + 1);
    localparam int FLAG_W   = NUM_CH + 3;
    localparam int ACC_CH   = NUM_CH - 1;
    localparam int F_OVF    = NUM_CH;
    localparam int F_WRAP   = NUM_CH + 1;
    localparam int F_ACC    = NUM_CH + 2;
    localparam int EDGE_LSB = NUM_CH;
    localparam int ACT_LSB  = 3 * NUM_CH;

    typedef struct packed {
        logic                  run;
        logic [SEL_W-1:0]      sel;
        logic [CNT_W-1:0]      cnt;
        logic [NUM_CH-1:0]     cmp_mode;
        logic [2*NUM_CH-1:0]   edge_sel;
        logic [2*NUM_CH-1:0]   act;
        logic [FLAG_W-1:0]     flags;
        logic [FLAG_W-1:0]     ien;
        logic                  acc_en;
        logic                  acc_gated;
        logic                  acc_pol;
    } top_st_t;

    top_st_t st_d, st_q;

    logic wr_ctrl, wr_cnt, wr_mode, wr_flags, wr_ien, wr_acc_ctrl, wr_acc_cnt;
    logic pre_tick, cnt_step;
    logic [NUM_CH-1:0] ch_hit;
    logic [CNT_W-1:0]  ch_val [NUM_CH];
    logic [CNT_W-1:0]  acc_cnt;
    logic              acc_wrap, acc_evt;
    logic [FLAG_W-1:0] flag_set, flag_clr;

    assign wr_ctrl     = bus_we && (bus_addr == ADDR_W'(REG_CTRL));
    assign wr_cnt      = bus_we && (bus_addr == ADDR_W'(REG_COUNT));
    assign wr_mode     = bus_we && (bus_addr == ADDR_W'(REG_MODE));
    assign wr_flags    = bus_we && (bus_addr == ADDR_W'(REG_FLAGS));
    assign wr_ien      = bus_we && (bus_addr == ADDR_W'(REG_IEN));
    assign wr_acc_ctrl = bus_we && (bus_addr == ADDR_W'(REG_ACC_CTRL));
    assign wr_acc_cnt  = bus_we && (bus_addr == ADDR_W'(REG_ACC_CNT));
    assign cnt_step    = pre_tick && !wr_cnt;

    qt_prescaler #(
        .STAGES (PRE_STAGES),
        .SEL_W  (SEL_W)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st_q.run),
        .sel  (st_q.sel),
        .tick (pre_tick)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam bit IS_ACC = (i == ACC_CH);
        qt_channel #(
            .CNT_W(CNT_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .blocked  (IS_ACC && st_q.acc_en),
            .cmp_mode (st_q.cmp_mode[i]),
            .edge_sel (st_q.edge_sel[2*i +: 2]),
            .act      (st_q.act[2*i +: 2]),
            .cnt_q    (st_q.cnt),
            .cnt_step (cnt_step),
            .val_wr   (bus_we && (bus_addr == ADDR_W'(REG_CHAN + i))),
            .val_wdata(bus_wdata[CNT_W-1:0]),
            .pin_i    (pin_i[i]),
            .pin_o    (pin_o[i]),
            .pin_oe   (pin_oe[i]),
            .value    (ch_val[i]),
            .hit      (ch_hit[i])
        );
    end

    qt_accum #(
        .CNT_W    (CNT_W),
        .GATE_LOG2(GATE_LOG2)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (st_q.acc_en),
        .gated    (st_q.acc_gated),
        .pol      (st_q.acc_pol),
        .pin_i    (pin_i[ACC_CH]),
        .load     (wr_acc_cnt),
        .load_data(bus_wdata[CNT_W-1:0]),
        .count    (acc_cnt),
        .wrap     (acc_wrap),
        .evt      (acc_evt)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.run = bus_wdata[0];
            st_d.sel = bus_wdata[SEL_W:1];
        end
        if (wr_cnt) begin
            st_d.cnt = bus_wdata[CNT_W-1:0];
        end else if (pre_tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (wr_mode) begin
            st_d.cmp_mode = bus_wdata[NUM_CH-1:0];
            st_d.edge_sel = bus_wdata[EDGE_LSB +: 2*NUM_CH];
            st_d.act      = bus_wdata[ACT_LSB +: 2*NUM_CH];
        end
        if (wr_ien) begin
            st_d.ien = bus_wdata[FLAG_W-1:0];
        end
        if (wr_acc_ctrl) begin
            st_d.acc_en    = bus_wdata[0];
            st_d.acc_gated = bus_wdata[1];
            st_d.acc_pol   = bus_wdata[2];
        end
        flag_set                 = '0;
        flag_set[NUM_CH-1:0]     = ch_hit;
        flag_set[F_OVF]          = cnt_step && (st_q.cnt == '1);
        flag_set[F_WRAP]         = acc_wrap;
        flag_set[F_ACC]          = acc_evt;
        flag_clr                 = wr_flags ? bus_wdata[FLAG_W-1:0] : '0;
        st_d.flags               = (st_q.flags & ~flag_clr) | flag_set;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_CTRL)) begin
            bus_rdata[SEL_W:0] = {st_q.sel, st_q.run};
        end else if (bus_addr == ADDR_W'(REG_COUNT)) begin
            bus_rdata[CNT_W-1:0] = st_q.cnt;
        end else if (bus_addr == ADDR_W'(REG_MODE)) begin
            bus_rdata[5*NUM_CH-1:0] = {st_q.act, st_q.edge_sel, st_q.cmp_mode};
        end else if (bus_addr == ADDR_W'(REG_FLAGS)) begin
            bus_rdata[FLAG_W-1:0] = st_q.flags;
        end else if (bus_addr == ADDR_W'(REG_IEN)) begin
            bus_rdata[FLAG_W-1:0] = st_q.ien;
        end else if (bus_addr == ADDR_W'(REG_ACC_CTRL)) begin
            bus_rdata[2:0] = {st_q.acc_pol, st_q.acc_gated, st_q.acc_en};
        end else if (bus_addr == ADDR_W'(REG_ACC_CNT)) begin
            bus_rdata[CNT_W-1:0] = acc_cnt;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ADDR_W'(REG_CHAN + i)) begin
                    bus_rdata[CNT_W-1:0] = ch_val[i];
                end
            end
        end
    end

    assign irq = |(st_q.flags & st_q.ien);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!pre_tick && !wr_cnt) |=> $stable(st_q.cnt)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (pre_tick && !wr_cnt) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R2
    AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) !st_q.run |-> !pre_tick); // R2
    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (pre_tick && !wr_cnt && st_q.cnt == '1) |=> st_q.flags[F_OVF]); // R3
    AST_ACC_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n) acc_wrap |=> st_q.flags[F_WRAP]); // R8
    AST_HIT_WINS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (|ch_hit) |=> ((st_q.flags[NUM_CH-1:0] & $past(ch_hit)) == $past(ch_hit))); // R10

endmodule

// File: tb/tb_quad_timer.sv
module tb_quad_timer;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          we    = 1'b0;
    logic [AW-1:0] addr  = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [3:0]    pin_i = '0;
    logic [3:0]    pin_o, pin_oe;
    logic          irq;

    int nvec = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    quad_timer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (we),
        .bus_addr (addr),
        .bus_wdata(wdata),
        .bus_rdata(rdata),
        .pin_i    (pin_i),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe),
        .irq      (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = AW'(a);
        #1;
        d = rdata;
    endtask

    task automatic pulse3();
        @(negedge clk); pin_i[3] = 1'b1;
        @(negedge clk); pin_i[3] = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c, c2, expv;
        logic [3:0]  exp_out;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and output
        for (int a = 0; a < 12; a++) begin
            if (a != 7) begin
                rd(a, v);
                check("R1 reg", v, 0);
            end
        end
        check("R1 oe", {28'd0, pin_oe}, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R2: divider sweep, count = floor(edges / 2^s)
        for (int s = 0; s < 8; s++) begin
            wr(0, 0);
            wr(1, 0);
            wr(0, 32'(1 | (s << 1)));
            repeat ((5 << s) - 2) @(negedge clk);
            rd(1, v);
            check("R2 div", v, 4);
            rd(1, v);
            check("R2 div", v, 5);
        end
        wr(0, 0);
        rd(1, c);
        repeat (7) @(negedge clk);
        rd(1, c2);
        check("R2 halt", c2, c);

        // R3: rollover flag observed through the interrupt (bit 4)
        wr(4, 32'h10);
        wr(1, 32'hFFFE);
        wr(0, 1);
        #1;
        check("R3 before", {31'd0, irq}, 0);
        rd(1, v);
        check("R3 count", v, 32'hFFFF);
        check("R3 no flag yet", {31'd0, irq}, 0);
        rd(1, v);
        check("R3 wrap", v, 0);
        check("R3 flag", {31'd0, irq}, 1);
        wr(0, 0);
        wr(3, 32'h7F);
        #1;
        check("R10 cleared", {31'd0, irq}, 0);

        // R4: capture on every edge code, every channel; R11 mask off
        wr(4, 0);
        wr(0, 1);
        for (int ch = 0; ch < 4; ch++) begin
            for (int code = 0; code < 4; code++) begin
                wr(2, 32'(code << (4 + 2 * ch)));
                wr(8 + ch, 0);
                wr(3, 32'h7F);
                expv = 0;
                rd(1, c);
                pin_i[ch] = 1'b1;
                rd(8 + ch, v);
                if (code[0]) expv = c;
                check("R4 rise value", v, expv);
                rd(3, v);
                check("R4 rise flag", (v >> ch) & 1, 32'(code[0]));
                check("R11 masked", {31'd0, irq}, 0);
                wr(3, 32'h7F);
                rd(1, c);
                pin_i[ch] = 1'b0;
                rd(8 + ch, v);
                if (code[1]) expv = c;
                check("R4 fall value", v, expv);
                rd(3, v);
                check("R4 fall flag", (v >> ch) & 1, 32'(code[1]));
            end
        end
        wr(0, 0);
        wr(2, 0);

        // R5: compare actions per channel, match at count 20
        exp_out = '0;
        for (int ch = 0; ch < 4; ch++) begin
            for (int k = 0; k < 4; k++) begin
                int act;
                act = (k == 0) ? 3 : (k == 1) ? 1 : (k == 2) ? 2 : 0;
                wr(0, 0);
                wr(3, 32'h7F);
                wr(1, 0);
                wr(8 + ch, 20);
                wr(2, 32'((1 << ch) | (act << (12 + 2 * ch))));
                wr(4, 32'(1 << ch));
                wr(0, 1);
                repeat (19) @(negedge clk);
                #1;
                check("R5 pre-match flag", {31'd0, irq}, 0);
                check("R5 pre-match pin", {31'd0, pin_o[ch]}, {31'd0, exp_out[ch]});
                @(negedge clk);
                #1;
                case (act)
                    1: exp_out[ch] = ~exp_out[ch];
                    2: exp_out[ch] = 1'b0;
                    3: exp_out[ch] = 1'b1;
                    default: exp_out[ch] = exp_out[ch];
                endcase
                check("R5 match flag", {31'd0, irq}, 1);
                check("R5 match pin", {31'd0, pin_o[ch]}, {31'd0, exp_out[ch]});
                check("R5 enable", {31'd0, pin_oe[ch]}, (act != 0) ? 1 : 0);
                if (act == 0) begin
                    wr(3, 0);
                    #1;
                    check("R10 zero write keeps", {31'd0, irq}, 1);
                    wr(3, 32'(1 << ch));
                    #1;
                    check("R10 one write clears", {31'd0, irq}, 0);
                end
            end
        end
        wr(0, 0);
        wr(4, 0);

        // R6 and R9: event mode rising, channel 3 set to capture both edges
        wr(0, 1);
        wr(2, 32'h3 << 10);
        wr(11, 32'h1234);
        wr(5, 1);
        wr(6, 0);
        wr(3, 32'h7F);
        repeat (5) pulse3();
        rd(6, v);
        check("R6 rising count", v, 5);
        rd(3, v);
        check("R6 event flag", (v >> 6) & 1, 1);
        check("R9 no ch3 flag", (v >> 3) & 1, 0);
        rd(11, v);
        check("R9 ch3 value kept", v, 32'h1234);

        // R6: falling polarity
        wr(5, 5);
        wr(6, 0);
        repeat (4) pulse3();
        rd(6, v);
        check("R6 falling count", v, 4);

        // R9: compare enable suppressed while the accumulator owns channel 3
        wr(2, 32'h8 | (32'h3 << 18));
        #1;
        check("R9 oe blocked", {31'd0, pin_oe[3]}, 0);
        wr(5, 0);
        #1;
        check("R9 oe released", {31'd0, pin_oe[3]}, 1);
        wr(2, 0);
        wr(0, 0);

        // R8: accumulator rollover
        wr(5, 1);
        wr(6, 32'hFFFF);
        wr(3, 32'h7F);
        pulse3();
        rd(6, v);
        check("R8 wrap count", v, 0);
        rd(3, v);
        check("R8 wrap flag", (v >> 5) & 1, 1);

        // R7: gated accumulation, 64-clock units, trailing-edge flag
        wr(5, 0);
        pin_i[3] = 1'b1;
        wr(6, 0);
        wr(3, 32'h7F);
        wr(5, 3);
        repeat (190) @(negedge clk);
        rd(6, v);
        check("R7 before third unit", v, 2);
        rd(6, v);
        check("R7 third unit", v, 3);
        rd(3, v);
        check("R7 no flag while open", (v >> 6) & 1, 0);
        pin_i[3] = 1'b0;
        rd(3, v);
        check("R7 trailing flag", (v >> 6) & 1, 1);
        repeat (200) @(negedge clk);
        rd(6, v);
        check("R7 held while closed", v, 3);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule